// File: doc/BRIEF.md
# JTAG-to-SPI Flash Bridge

This block is a small JTAG test access port that lets a host program a serial flash through an ordinary JTAG cable. It tracks the sixteen-state TAP controller and holds an instruction register. Under IDCODE or BYPASS it behaves like any other device on the chain. When the designated user instruction is loaded, the data-register path stops being an on-chip register and becomes a wire-level link to the flash:

- TDI drives the flash data input.
- TCK is the flash clock.
- The flash data output is returned on TDO.
- Chip select is asserted only while the controller sits in Shift-DR.

The host builds every flash command itself by shifting bits through DR. One DR scan is exactly one SPI transaction.

The block has no SPI engine, divider or second clock domain. Everything runs on TCK, and the host paces all traffic, so there is no valid/ready handshake and no back-pressure. A flash that samples its input on the rising clock edge and updates its output after that edge sees SPI mode 0 timing. The bridge captures MISO on the TCK falling edge, so the host reads flash output bit k before shift edge k+1, which is the same place it would read bit k of an on-chip register.

Top module: `jtag_spi_bridge`

## Requirements
- R1: The TAP controller follows the standard 16-state graph on TCK rising edges under TMS. Five consecutive rising edges with TMS high leave it in Test-Logic-Reset from any state.
- R2: While trst_n is low, the controller is held in Test-Logic-Reset and the instruction becomes IDCODE, without waiting for TCK. During that time spi_cs_n is high and tdo_oe is low.
- R3: The instruction register is 6 bits wide.
  - At the rising edge that leaves Capture-IR it loads 6'b000001.
  - In Shift-IR it shifts LSB first from TDI, so the host reads the captured bit 0 (value 1) first.
  - A new instruction takes effect at the rising edge that leaves Update-IR.
- R4: The IDCODE opcode defaults to 6'b001001 and is the instruction after any reset. It selects a 32-bit register that loads ID_VALUE (default 32'h4C6A2E3D, bit 0 set) when leaving Capture-DR, and shifts it out LSB first.
- R5: BYPASS (6'b111111) and every opcode that is not assigned select a 1-bit register. That register loads 0 when leaving Capture-DR, so the first bit read in a DR scan is 0 and each later bit read is the TDI bit shifted one edge earlier.
- R6: spi_cs_n is low only while the state is Shift-DR and the instruction equals the user opcode (default 6'b000010). It is high in every other state and under every other instruction, so each DR scan under the user opcode forms exactly one chip-select low period.
- R7: spi_mosi always equals tdi, and spi_sclk always equals tck.
- R8: Under the user opcode in Shift-DR, tdo presents the spi_miso level captured at the TCK falling edge.
- R9: tdo and tdo_oe change only on TCK falling edges. tdo_oe is high only during Shift-IR and Shift-DR.
- R10: Reaching Test-Logic-Reset through TMS restores the IDCODE instruction, whatever instruction was loaded before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; also the flash clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on TCK rising edge |
| tdi | input | 1 | Test data in; forwarded to the flash data input |
| spi_miso | input | 1 | Serial data from the flash |
| tdo | output | 1 | Test data out, updated on TCK falling edge |
| tdo_oe | output | 1 | High when tdo should be driven onto the chain |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_sclk | output | 1 | Flash clock |
| spi_cs_n | output | 1 | Flash chip select, active low, idle high |

## Verification
The in-RTL assertions check the following on every TCK edge:
- the five-edge return to Test-Logic-Reset;
- the IR capture pattern, IR update, and instruction restore on reset;
- the BYPASS and IDCODE capture values;
- that chip select stays low through Shift-DR and releases when TMS leaves it, and that it only falls after Capture-DR;
- that tdo_oe is confined to the shift states;
- that tdo follows MISO under the user opcode.

Only the bench scenarios can show the end-to-end results:
- the flash receives exactly the TDI bits of the scan, in order;
- the host reads the flash response bit-aligned;
- the IDCODE and BYPASS readback values are correct;
- an asynchronous reset in the middle of a flash transaction ends it at once.

// File: rtl/jsb_pkg.sv
package jsb_pkg;

  typedef enum logic [3:0] {
    TAP_RESET    = 4'h0,
    TAP_IDLE     = 4'h1,
    TAP_SEL_DR   = 4'h2,
    TAP_CAP_DR   = 4'h3,
    TAP_SHIFT_DR = 4'h4,
    TAP_EXIT1_DR = 4'h5,
    TAP_PAUSE_DR = 4'h6,
    TAP_EXIT2_DR = 4'h7,
    TAP_UPD_DR   = 4'h8,
    TAP_SEL_IR   = 4'h9,
    TAP_CAP_IR   = 4'hA,
    TAP_SHIFT_IR = 4'hB,
    TAP_EXIT1_IR = 4'hC,
    TAP_PAUSE_IR = 4'hD,
    TAP_EXIT2_IR = 4'hE,
    TAP_UPD_IR   = 4'hF
  } tap_state_t;

  function automatic tap_state_t tap_next(input tap_state_t cur, input logic tms);
    tap_state_t nxt;
    case (cur)
      TAP_RESET:    nxt = tms ? TAP_RESET    : TAP_IDLE;
      TAP_IDLE:     nxt = tms ? TAP_SEL_DR   : TAP_IDLE;
      TAP_SEL_DR:   nxt = tms ? TAP_SEL_IR   : TAP_CAP_DR;
      TAP_CAP_DR:   nxt = tms ? TAP_EXIT1_DR : TAP_SHIFT_DR;
      TAP_SHIFT_DR: nxt = tms ? TAP_EXIT1_DR : TAP_SHIFT_DR;
      TAP_EXIT1_DR: nxt = tms ? TAP_UPD_DR   : TAP_PAUSE_DR;
      TAP_PAUSE_DR: nxt = tms ? TAP_EXIT2_DR : TAP_PAUSE_DR;
      TAP_EXIT2_DR: nxt = tms ? TAP_UPD_DR   : TAP_SHIFT_DR;
      TAP_UPD_DR:   nxt = tms ? TAP_SEL_DR   : TAP_IDLE;
      TAP_SEL_IR:   nxt = tms ? TAP_RESET    : TAP_CAP_IR;
      TAP_CAP_IR:   nxt = tms ? TAP_EXIT1_IR : TAP_SHIFT_IR;
      TAP_SHIFT_IR: nxt = tms ? TAP_EXIT1_IR : TAP_SHIFT_IR;
      TAP_EXIT1_IR: nxt = tms ? TAP_UPD_IR   : TAP_PAUSE_IR;
      TAP_PAUSE_IR: nxt = tms ? TAP_EXIT2_IR : TAP_PAUSE_IR;
      TAP_EXIT2_IR: nxt = tms ? TAP_UPD_IR   : TAP_SHIFT_IR;
      TAP_UPD_IR:   nxt = tms ? TAP_SEL_DR   : TAP_IDLE;
      default:      nxt = TAP_RESET;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/jsb_tap_ctrl.sv
module jsb_tap_ctrl
  import jsb_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_t state
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= TAP_RESET;
    else         state <= tap_next(state, tms);
  end

  // Run length of consecutive TMS-high edges, saturating at five.
  logic [2:0] tms_run;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)               tms_run <= 3'd0;
    else if (!tms)             tms_run <= 3'd0;
    else if (tms_run != 3'd5)  tms_run <= tms_run + 3'd1;
  end

  // R1
  five_tms_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (tms_run == 3'd5) |-> (state == TAP_RESET));

endmodule

// File: rtl/jsb_ir.sv
module jsb_ir
  import jsb_pkg::*;
#(
  parameter int              IR_W     = 6,
  parameter logic [IR_W-1:0] RESET_OP = {IR_W{1'b1}}
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_t      state,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_sout
);

  localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-1){1'b0}}, 1'b1};

  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh <= CAP_PAT;
    end else begin
      case (state)
        TAP_CAP_IR:   ir_sh <= CAP_PAT;
        TAP_SHIFT_IR: ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        default:      ir_sh <= ir_sh;
      endcase
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                  ir_q <= RESET_OP;
    else if (state == TAP_RESET)  ir_q <= RESET_OP;
    else if (state == TAP_UPD_IR) ir_q <= ir_sh;
  end

  assign ir_sout = ir_sh[0];

  // R3
  ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TAP_CAP_IR) |=> (ir_sh == CAP_PAT));

  // R3
  ir_update_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TAP_UPD_IR) |=> (ir_q == $past(ir_sh)));

  // R10
  ir_restore_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TAP_RESET) |=> (ir_q == RESET_OP));

endmodule

// File: rtl/jsb_dr_regs.sv
module jsb_dr_regs
  import jsb_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = {{(ID_W-1){1'b0}}, 1'b1}
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tdi,
  input  tap_state_t state,
  output logic       byp_sout,
  output logic       id_sout
);

  logic            byp_q;
  logic [ID_W-1:0] id_sh;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
      id_sh <= ID_VALUE;
    end else begin
      case (state)
        TAP_CAP_DR: begin
          byp_q <= 1'b0;
          id_sh <= ID_VALUE;
        end
        TAP_SHIFT_DR: begin
          byp_q <= tdi;
          id_sh <= {tdi, id_sh[ID_W-1:1]};
        end
        default: begin
          byp_q <= byp_q;
          id_sh <= id_sh;
        end
      endcase
    end
  end

  assign byp_sout = byp_q;
  assign id_sout  = id_sh[0];

  // R5
  bypass_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TAP_CAP_DR) |=> (byp_q == 1'b0));

  // R4
  idcode_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TAP_CAP_DR) |=> (id_sh == ID_VALUE));

endmodule

// File: rtl/jsb_tdo_stage.sv
module jsb_tdo_stage
  import jsb_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  tap_state_t state,
  input  logic       sel_user,
  input  logic       sel_id,
  input  logic       ir_sout,
  input  logic       id_sout,
  input  logic       byp_sout,
  input  logic       spi_miso,
  output logic       tdo,
  output logic       tdo_oe
);

  logic nxt_bit;
  logic nxt_oe;

  always_comb begin
    nxt_bit = 1'b0;
    nxt_oe  = 1'b0;
    case (state)
      TAP_SHIFT_IR: begin
        nxt_bit = ir_sout;
        nxt_oe  = 1'b1;
      end
      TAP_SHIFT_DR: begin
        nxt_oe = 1'b1;
        if (sel_user)    nxt_bit = spi_miso;
        else if (sel_id) nxt_bit = id_sout;
        else             nxt_bit = byp_sout;
      end
      default: begin
        nxt_bit = 1'b0;
        nxt_oe  = 1'b0;
      end
    endcase
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= nxt_bit;
      tdo_oe <= nxt_oe;
    end
  end

  // R9
  tdo_oe_window_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state inside {TAP_SHIFT_IR, TAP_SHIFT_DR}));

  // R8
  miso_passthru_chk: assert property (@(negedge tck) disable iff (!trst_n)
    (state == TAP_SHIFT_DR && sel_user) |=> (tdo == $past(spi_miso)));

endmodule

// File: rtl/jtag_spi_bridge.sv
module jtag_spi_bridge
  import jsb_pkg::*;
#(
  parameter int              IR_W      = 6,
  parameter logic [IR_W-1:0] USER_OP   = 6'b000010,
  parameter logic [IR_W-1:0] IDCODE_OP = 6'b001001,
  parameter int              ID_W      = 32,
  parameter logic [ID_W-1:0] ID_VALUE  = 32'h4C6A_2E3D
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic spi_miso,
  output logic tdo,
  output logic tdo_oe,
  output logic spi_mosi,
  output logic spi_sclk,
  output logic spi_cs_n
);

  localparam logic [IR_W-1:0] BYPASS_OP = {IR_W{1'b1}};

  tap_state_t      state;
  logic [IR_W-1:0] ir_q;
  logic            ir_sout;
  logic            id_sout;
  logic            byp_sout;
  logic            sel_user;
  logic            sel_id;

  jsb_tap_ctrl u_tap (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (state)
  );

  jsb_ir #(
    .IR_W     (IR_W),
    .RESET_OP (IDCODE_OP)
  ) u_ir (
    .tck     (tck),
    .trst_n  (trst_n),
    .tdi     (tdi),
    .state   (state),
    .ir_q    (ir_q),
    .ir_sout (ir_sout)
  );

  jsb_dr_regs #(
    .ID_W     (ID_W),
    .ID_VALUE (ID_VALUE)
  ) u_dr (
    .tck      (tck),
    .trst_n   (trst_n),
    .tdi      (tdi),
    .state    (state),
    .byp_sout (byp_sout),
    .id_sout  (id_sout)
  );

  // Everything other than the user and IDCODE opcodes, BYPASS_OP
  // included, falls through to the 1-bit bypass path.
  assign sel_user = (ir_q == USER_OP) && (USER_OP != BYPASS_OP);
  assign sel_id   = (ir_q == IDCODE_OP) && !sel_user;

  jsb_tdo_stage u_tdo (
    .tck      (tck),
    .trst_n   (trst_n),
    .state    (state),
    .sel_user (sel_user),
    .sel_id   (sel_id),
    .ir_sout  (ir_sout),
    .id_sout  (id_sout),
    .byp_sout (byp_sout),
    .spi_miso (spi_miso),
    .tdo      (tdo),
    .tdo_oe   (tdo_oe)
  );

  assign spi_mosi = tdi;
  assign spi_sclk = tck;
  assign spi_cs_n = !(sel_user && (state == TAP_SHIFT_DR));

  // R6
  cs_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (!spi_cs_n && !tms) |=> !spi_cs_n);

  // R6
  cs_release_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (!spi_cs_n && tms) |=> spi_cs_n);

  // R6
  cs_entry_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $fell(spi_cs_n) |-> ($past(state) == TAP_CAP_DR));

endmodule

// File: tb/jtag_spi_bridge_tb_top.sv
module jtag_spi_bridge_tb_top;

  localparam int CLK_PERIOD = 20;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam logic [5:0]  OP_USER = 6'b000010;
  localparam logic [5:0]  OP_BYP  = 6'b111111;
  localparam logic [5:0]  OP_FREE = 6'b010101;
  localparam logic [31:0] ID_EXP  = 32'h4C6A_2E3D;

  logic tck = 1'b0;
  logic trst_n, tms, tdi;
  logic spi_miso, tdo, tdo_oe, spi_mosi, spi_sclk, spi_cs_n;

  always #(HALF) tck = ~tck;

  jtag_spi_bridge dut_i (
    .tck      (tck),
    .trst_n   (trst_n),
    .tms      (tms),
    .tdi      (tdi),
    .spi_miso (spi_miso),
    .tdo      (tdo),
    .tdo_oe   (tdo_oe),
    .spi_mosi (spi_mosi),
    .spi_sclk (spi_sclk),
    .spi_cs_n (spi_cs_n)
  );

  // Flash model: a shift register clocked on SCLK rising edges.
  logic        fl_sel = 1'b0;
  logic [5:0]  fl_cnt = 6'd0;
  logic [31:0] fl_rx  = 32'd0;
  logic [31:0] fl_resp;

  always @(negedge spi_sclk) fl_sel <= (spi_cs_n === 1'b0);
  always @(posedge spi_sclk) begin
    if (fl_sel) begin
      fl_rx  <= {fl_rx[30:0], spi_mosi};
      fl_cnt <= fl_cnt + 6'd1;
    end else begin
      fl_cnt <= 6'd0;
    end
  end
  assign spi_miso = fl_resp[5'd31 - fl_cnt[4:0]];

  int checks = 0, fails = 0;
  int cs_err = 0, oe_err = 0, wire_err = 0, stab_err = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rev_n(input logic [31:0] x, input int n);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = x[n-1-i];
    return r;
  endfunction

  function automatic logic [31:0] mask_n(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  function automatic logic [31:0] bypass_exp(input logic [31:0] data, input int n);
    logic [31:0] r = '0;
    for (int i = 1; i < n; i++) r[i] = data[i-1];
    return r;
  endfunction

  // One TCK cycle: drive after the falling edge, sample just before the rise.
  task automatic tick(input logic t_ms, input logic t_di, input logic exp_cs_low,
                      input logic exp_oe, output logic t_do);
    @(negedge tck);
    #1;
    tms = t_ms;
    tdi = t_di;
    #(HALF - 3);
    t_do = tdo;
    if (spi_cs_n !== !exp_cs_low) cs_err++;
    if (tdo_oe !== exp_oe) oe_err++;
    if (spi_mosi !== tdi || spi_sclk !== 1'b0) wire_err++;
    @(posedge tck);
    #1;
    if (spi_sclk !== 1'b1) wire_err++;
    if (tdo !== t_do) stab_err++;
  endtask

  task automatic report_lines();
    chk(cs_err == 0,   "R6 chip select window errors", cs_err, 0);
    chk(oe_err == 0,   "R9 output enable window errors", oe_err, 0);
    chk(wire_err == 0, "R7 mosi/sclk pass-through errors", wire_err, 0);
    chk(stab_err == 0, "R9 tdo moved on rising edge", stab_err, 0);
    cs_err = 0; oe_err = 0; wire_err = 0; stab_err = 0;
  endtask

  task automatic scan_ir(input logic [5:0] op, output logic [5:0] cap);
    logic d;
    tick(1'b1, 1'b0, 1'b0, 1'b0, d);
    tick(1'b1, 1'b0, 1'b0, 1'b0, d);
    tick(1'b0, 1'b0, 1'b0, 1'b0, d);
    tick(1'b0, 1'b0, 1'b0, 1'b0, d);
    for (int i = 0; i < 6; i++) begin
      tick(i == 5, op[i], 1'b0, 1'b1, d);
      cap[i] = d;
    end
    tick(1'b1, 1'b0, 1'b0, 1'b0, d);
    tick(1'b0, 1'b0, 1'b0, 1'b0, d);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] data, input logic user,
                         output logic [31:0] dout);
    logic d;
    dout = '0;
    tick(1'b1, 1'b0, 1'b0, 1'b0, d);
    tick(1'b0, 1'b0, 1'b0, 1'b0, d);
    tick(1'b0, 1'b0, 1'b0, 1'b0, d);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, data[i], user, 1'b1, d);
      dout[i] = d;
    end
    tick(1'b1, 1'b0, 1'b0, 1'b0, d);
    tick(1'b0, 1'b0, 1'b0, 1'b0, d);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL R1 watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] dout, data;
    logic [5:0]  cap;
    logic        d;
    int          n;
    void'($urandom(32'd7741));
    trst_n  = 1'b0;
    tms     = 1'b1;
    tdi     = 1'b0;
    fl_resp = 32'd0;
    #(CLK_PERIOD * 3 + 3);
    // R2 reset state at the ports
    chk(spi_cs_n === 1'b1, "R2 cs_n during reset", {31'd0, spi_cs_n}, 32'd1);
    chk(tdo_oe === 1'b0,   "R2 tdo_oe during reset", {31'd0, tdo_oe}, 32'd0);
    @(negedge tck);
    #2 trst_n = 1'b1;
    tick(1'b0, 1'b0, 1'b0, 1'b0, d);

    // R4 IDCODE is the default instruction
    scan_dr(32, $urandom, 1'b0, dout);
    chk(dout == ID_EXP, "R4 idcode after reset", dout, ID_EXP);
    report_lines();

    // R3 capture pattern, then R5 bypass with random lengths
    scan_ir(OP_BYP, cap);
    chk(cap == 6'b000001, "R3 IR capture readback", {26'd0, cap}, 32'd1);
    for (int k = 0; k < 3; k++) begin
      n = 8 + int'($urandom % 25);
      data = $urandom;
      scan_dr(n, data, 1'b0, dout);
      chk((dout & mask_n(n)) == bypass_exp(data, n), "R5 bypass delay",
          dout & mask_n(n), bypass_exp(data, n));
    end
    scan_ir(OP_FREE, cap);
    chk(cap == 6'b000001, "R3 IR capture readback again", {26'd0, cap}, 32'd1);
    data = $urandom;
    scan_dr(20, data, 1'b0, dout);
    chk((dout & mask_n(20)) == bypass_exp(data, 20), "R5 unassigned opcode is bypass",
        dout & mask_n(20), bypass_exp(data, 20));
    report_lines();

    // R6 R7 R8 flash transactions under the user opcode
    scan_ir(OP_USER, cap);
    for (int k = 0; k < 6; k++) begin
      n = (k == 0) ? 1 : (k == 1) ? 32 : 1 + int'($urandom % 32);
      data = $urandom;
      fl_resp = $urandom;
      scan_dr(n, data, 1'b1, dout);
      chk((dout & mask_n(n)) == rev_n(fl_resp >> (32 - n), n), "R8 tdo returns miso",
          dout & mask_n(n), rev_n(fl_resp >> (32 - n), n));
      chk((fl_rx & mask_n(n)) == rev_n(data, n), "R7 flash received tdi bits",
          fl_rx & mask_n(n), rev_n(data, n));
    end
    // R6 an IR scan under the user opcode keeps chip select high
    scan_ir(OP_USER, cap);
    report_lines();

    // R10 R1 five TMS-high edges restore IDCODE
    for (int k = 0; k < 5; k++) tick(1'b1, 1'b0, 1'b0, 1'b0, d);
    tick(1'b0, 1'b0, 1'b0, 1'b0, d);
    scan_dr(32, $urandom, 1'b0, dout);
    chk(dout == ID_EXP, "R10 idcode after TMS reset", dout, ID_EXP);
    report_lines();

    // R2 asynchronous reset in the middle of a flash transaction
    scan_ir(OP_USER, cap);
    tick(1'b1, 1'b0, 1'b0, 1'b0, d);
    tick(1'b0, 1'b0, 1'b0, 1'b0, d);
    tick(1'b0, 1'b0, 1'b0, 1'b0, d);
    for (int k = 0; k < 3; k++) tick(1'b0, 1'b1, 1'b1, 1'b1, d);
    @(negedge tck);
    #2 trst_n = 1'b0;
    #1;
    chk(spi_cs_n === 1'b1, "R2 cs_n released by trst", {31'd0, spi_cs_n}, 32'd1);
    chk(tdo_oe === 1'b0,   "R2 tdo_oe cleared by trst", {31'd0, tdo_oe}, 32'd0);
    @(negedge tck);
    #2 trst_n = 1'b1;
    tick(1'b0, 1'b0, 1'b0, 1'b0, d);
    scan_dr(32, $urandom, 1'b0, dout);
    chk(dout == ID_EXP, "R2 idcode after trst", dout, ID_EXP);
    report_lines();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule